// File: doc/BRIEF.md
# Serial Channel Command Decoder and Break-Capable Transmitter

This block holds the command side and the transmit side of one serial channel. A host writes an 8-bit command word. The block splits that word into enable and disable actions for the receiver and the transmitter, plus a 3-bit command code. The code either fires a one-cycle strobe toward neighbouring logic (receiver, error status, break-change interrupt, mode pointer) or acts on the transmitter itself. Transmitter actions are reset, start break and stop break.

The transmitter has a one-character holding register in front of a shift register. It sends fixed 8N1 frames. Timing comes from an oversampling clock enable, and `OVS` pulses of that enable make one bit time. The bit-time counter runs freely, so every line change falls on a bit boundary. A break drives the line low. It is queued behind the character being sent and behind every character in the holding register, including characters written after the break request. When the break is released, the line is held high for one whole bit before the next character starts.

Top module: `uart_cmd_tx`

## Requirements
- R1: Command bit 7 has no effect. Bit 3 disables the transmitter, bit 2 enables it, bit 1 disables the receiver and bit 0 enables it. When the enable and disable bits for one direction are both set in one write, the disable wins.
- R2: `rx_en_o` is low after reset, set by bit 0 and cleared by bit 1. Code 010 in bits [6:4] (receiver reset) also clears it, and this overrides bit 0 in the same write.
- R3: Codes 001, 010, 100 and 101 in bits [6:4] pulse `mr_ptr_rst_o`, `rx_rst_o`, `err_clr_o` and `brk_int_clr_o` respectively. Each pulse is high for exactly one cycle, the cycle after the write, and the other three strobes stay low.
- R4: Enabling an idle, empty transmitter raises `tx_rdy_o` and `tx_empty_o` in the cycle after the write. A disable write drops both flags in the cycle after the write.
- R5: A frame on `txd_o` is one low start bit, 8 data bits sent LSB first, then one high stop bit, each lasting `OVS` tick pulses. The line idles high and changes only on a tick or on a command write.
- R6: A data write is accepted only while `tx_rdy_o` is high. `tx_rdy_o` stays low while the holding register is occupied. Data writes made while the register is full or while the transmitter is disabled are dropped.
- R7: A character waiting in the holding register starts on the bit boundary right after the previous stop bit, with no idle gap.
- R8: Characters that are shifting or held when the transmitter is disabled are still sent in full.
- R9: Start break (code 110) is accepted only if the transmitter was enabled before the write. With the transmitter empty, the line goes low within two bit times.
- R10: A break starts only after the character in flight and every held character have been sent, including characters loaded after the break request.
- R11: After stop break (code 111), the line returns high within two bit times and stays high for at least one bit time before the next start bit.
- R12: Transmitter reset (code 011) sets the line high, disables the transmitter, empties the holding register and drops any break, all in the cycle after the write.
- R13: `tx_empty_o` is high only while the transmitter is enabled, the holding register is empty, and no frame or break is on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command word write strobe |
| cmd_i | input | 8 | Command word |
| data_we_i | input | 1 | Transmit data write strobe |
| data_i | input | DATA_W | Transmit character |
| tick16_i | input | 1 | Oversampling clock enable, OVS pulses per bit |
| txd_o | output | 1 | Serial transmit line |
| tx_rdy_o | output | 1 | Holding register can take a character |
| tx_empty_o | output | 1 | Transmitter enabled and completely idle |
| rx_en_o | output | 1 | Receiver enable state |
| mr_ptr_rst_o | output | 1 | Mode pointer reset strobe |
| rx_rst_o | output | 1 | Receiver reset strobe |
| err_clr_o | output | 1 | Error status clear strobe |
| brk_int_clr_o | output | 1 | Break-change interrupt clear strobe |

## Verification
The bench builds the block with `DATA_W` = 8 and `OVS` = 4, and drives the tick on every other clock, so one bit time is eight clocks. This short bit time lets back-to-back frames, breaks queued behind two characters, the release-and-mark sequence, and resets in the middle of a frame all fit in a short run. Because the tick is gapped, the checks also confirm that the line changes only on tick cycles.

// File: rtl/uart_cmd_pkg.sv
package uart_cmd_pkg;

  typedef enum logic [2:0] {
    MISC_NONE        = 3'd0,
    MISC_MR_PTR      = 3'd1,
    MISC_RX_RST      = 3'd2,
    MISC_TX_RST      = 3'd3,
    MISC_ERR_CLR     = 3'd4,
    MISC_BRK_INT_CLR = 3'd5,
    MISC_BRK_START   = 3'd6,
    MISC_BRK_STOP    = 3'd7
  } misc_cmd_e;

  typedef struct packed {
    logic tx_en;
    logic tx_dis;
    logic tx_rst;
    logic brk_start;
    logic brk_stop;
  } tx_act_t;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_SHIFT,
    TX_BREAK,
    TX_MARK
  } tx_state_e;

  localparam int unsigned N_STB = 4;
  // strobe order: mode pointer, receiver reset, error clear, break-change clear
  localparam misc_cmd_e STB_CODE [N_STB] =
    '{MISC_MR_PTR, MISC_RX_RST, MISC_ERR_CLR, MISC_BRK_INT_CLR};

endpackage

// File: rtl/uart_cmd_decode.sv
module uart_cmd_decode
  import uart_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_we_i,
  input  logic [6:0]       cmd_i,
  output tx_act_t          tx_act_o,
  output logic             rx_en_o,
  output logic [N_STB-1:0] stb_o
);

  logic [2:0] misc;
  logic       rx_off, rx_on;

  assign misc = cmd_i[6:4];

  always_comb begin
    tx_act_o           = '0;
    tx_act_o.tx_en     = cmd_we_i & cmd_i[2];
    tx_act_o.tx_dis    = cmd_we_i & cmd_i[3];
    tx_act_o.tx_rst    = cmd_we_i & (misc == MISC_TX_RST);
    tx_act_o.brk_start = cmd_we_i & (misc == MISC_BRK_START);
    tx_act_o.brk_stop  = cmd_we_i & (misc == MISC_BRK_STOP);
  end

  assign rx_off = cmd_we_i & (cmd_i[1] | (misc == MISC_RX_RST));
  assign rx_on  = cmd_we_i & cmd_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rx_en_o <= 1'b0;
    else if (rx_off) rx_en_o <= 1'b0;
    else if (rx_on)  rx_en_o <= 1'b1;
  end

  for (genvar g = 0; g < N_STB; g++) begin : g_stb
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stb_o[g] <= 1'b0;
      else         stb_o[g] <= cmd_we_i & (misc == STB_CODE[g]);
    end
  end

endmodule

// File: rtl/uart_bit_timer.sv
module uart_bit_timer #(
  parameter int unsigned OVS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic bit_stb_o
);

  localparam int unsigned CNT_W = (OVS > 2) ? $clog2(OVS) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(OVS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign bit_stb_o = tick_i & (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clr_i)     cnt_q <= '0;
    else if (bit_stb_o) cnt_q <= '0;
    else if (tick_i)    cnt_q <= cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
  import uart_cmd_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tx_act_t           act_i,
  input  logic              data_we_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              tick_i,
  output logic              txd_o,
  output logic              tx_rdy_o,
  output logic              tx_empty_o
);

  localparam int unsigned IDX_W = $clog2(DATA_W + 2);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W + 1);

  tx_state_e         state_q;
  logic              tx_en_q, brk_req_q, thr_full_q, txd_q;
  logic [DATA_W-1:0] thr_q;
  logic [DATA_W:0]   sh_q;
  logic [IDX_W-1:0]  idx_q;

  logic bit_stb, wr_ok, can_launch;
  logic launch_chr, launch_brk, go_idle, shift_step, to_mark;

  uart_bit_timer #(.OVS(OVS)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (act_i.tx_rst),
    .tick_i   (tick_i),
    .bit_stb_o(bit_stb)
  );

  assign tx_rdy_o   = tx_en_q & ~thr_full_q;
  assign tx_empty_o = tx_rdy_o & (state_q == TX_IDLE);
  assign txd_o      = txd_q;
  assign wr_ok      = data_we_i & tx_rdy_o;

  // boundary where the next line activity may be chosen
  assign can_launch = (state_q == TX_IDLE) | (state_q == TX_MARK) |
                      ((state_q == TX_SHIFT) & (idx_q == IDX_LAST));
  assign launch_chr = bit_stb & can_launch & thr_full_q;
  assign launch_brk = bit_stb & can_launch & ~thr_full_q & brk_req_q;
  assign go_idle    = bit_stb & can_launch & ~thr_full_q & ~brk_req_q;
  assign shift_step = bit_stb & (state_q == TX_SHIFT) & (idx_q != IDX_LAST);
  assign to_mark    = bit_stb & (state_q == TX_BREAK) & ~brk_req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= TX_IDLE;
      tx_en_q    <= 1'b0;
      brk_req_q  <= 1'b0;
      thr_full_q <= 1'b0;
      thr_q      <= '0;
      sh_q       <= '1;
      idx_q      <= '0;
      txd_q      <= 1'b1;
    end else if (act_i.tx_rst) begin
      state_q    <= TX_IDLE;
      tx_en_q    <= 1'b0;
      brk_req_q  <= 1'b0;
      thr_full_q <= 1'b0;
      thr_q      <= '0;
      sh_q       <= '1;
      idx_q      <= '0;
      txd_q      <= 1'b1;
    end else begin
      if (act_i.tx_dis)     tx_en_q <= 1'b0;
      else if (act_i.tx_en) tx_en_q <= 1'b1;

      if (act_i.brk_stop)                      brk_req_q <= 1'b0;
      else if (act_i.brk_start && tx_en_q)     brk_req_q <= 1'b1;

      if (wr_ok) begin
        thr_full_q <= 1'b1;
        thr_q      <= data_i;
      end else if (launch_chr) begin
        thr_full_q <= 1'b0;
      end

      if (launch_chr) begin
        state_q <= TX_SHIFT;
        txd_q   <= 1'b0;
        sh_q    <= {1'b1, thr_q};
        idx_q   <= '0;
      end else if (launch_brk) begin
        state_q <= TX_BREAK;
        txd_q   <= 1'b0;
      end else if (go_idle) begin
        state_q <= TX_IDLE;
        txd_q   <= 1'b1;
      end else if (shift_step) begin
        txd_q <= sh_q[0];
        sh_q  <= {1'b1, sh_q[DATA_W:1]};
        idx_q <= idx_q + IDX_W'(1);
      end else if (to_mark) begin
        state_q <= TX_MARK;
        txd_q   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/uart_cmd_tx.sv
module uart_cmd_tx
  import uart_cmd_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OVS    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [7:0]        cmd_i,
  input  logic              data_we_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              tick16_i,
  output logic              txd_o,
  output logic              tx_rdy_o,
  output logic              tx_empty_o,
  output logic              rx_en_o,
  output logic              mr_ptr_rst_o,
  output logic              rx_rst_o,
  output logic              err_clr_o,
  output logic              brk_int_clr_o
);

  tx_act_t          tx_act;
  logic [N_STB-1:0] stb;
  logic             unused_cmd_msb;

  assign unused_cmd_msb = cmd_i[7];

  uart_cmd_decode u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_we_i(cmd_we_i),
    .cmd_i   (cmd_i[6:0]),
    .tx_act_o(tx_act),
    .rx_en_o (rx_en_o),
    .stb_o   (stb)
  );

  uart_tx_engine #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_i     (tx_act),
    .data_we_i (data_we_i),
    .data_i    (data_i),
    .tick_i    (tick16_i),
    .txd_o     (txd_o),
    .tx_rdy_o  (tx_rdy_o),
    .tx_empty_o(tx_empty_o)
  );

  assign mr_ptr_rst_o  = stb[0];
  assign rx_rst_o      = stb[1];
  assign err_clr_o     = stb[2];
  assign brk_int_clr_o = stb[3];

endmodule

// File: rtl/uart_cmd_tx_chk.sv
module uart_cmd_tx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_we_i,
  input logic [7:0] cmd_i,
  input logic       data_we_i,
  input logic       tick16_i,
  input logic       txd_o,
  input logic       tx_rdy_o,
  input logic       tx_empty_o,
  input logic       rx_en_o,
  input logic       mr_ptr_rst_o,
  input logic       rx_rst_o,
  input logic       err_clr_o,
  input logic       brk_int_clr_o
);

  AST_TX_DIS_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_i[3]) |=> (!tx_rdy_o && !tx_empty_o)); // R1

  AST_RX_DIS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_i[1]) |=> !rx_en_o); // R2

  AST_RX_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_i[0] && !cmd_i[1] && cmd_i[6:4] != 3'b010) |=> rx_en_o); // R2

  AST_RX_RST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rst_o |-> ($past(cmd_we_i) && $past(cmd_i[6:4]) == 3'b010)); // R3

  AST_ERR_CLR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_i[6:4] == 3'b100) |=> err_clr_o); // R3

  AST_STB_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mr_ptr_rst_o, rx_rst_o, err_clr_o, brk_int_clr_o})); // R3

  AST_TXD_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick16_i && !cmd_we_i) |=> $stable(txd_o)); // R5

  AST_RDY_DROPS_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i && tx_rdy_o) |=> !tx_rdy_o); // R6

  AST_TX_RST_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_i[6:4] == 3'b011) |=> (txd_o && !tx_rdy_o && !tx_empty_o)); // R12

  AST_EMPTY_NEEDS_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> tx_rdy_o); // R13

endmodule

bind uart_cmd_tx uart_cmd_tx_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_we_i     (cmd_we_i),
  .cmd_i        (cmd_i),
  .data_we_i    (data_we_i),
  .tick16_i     (tick16_i),
  .txd_o        (txd_o),
  .tx_rdy_o     (tx_rdy_o),
  .tx_empty_o   (tx_empty_o),
  .rx_en_o      (rx_en_o),
  .mr_ptr_rst_o (mr_ptr_rst_o),
  .rx_rst_o     (rx_rst_o),
  .err_clr_o    (err_clr_o),
  .brk_int_clr_o(brk_int_clr_o)
);

// File: tb/uart_cmd_tx_test.sv
module uart_cmd_tx_test;

  localparam int BIT = 8; // OVS=4, tick every 2nd clock

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_we = 1'b0;
  logic [7:0] cmd = '0;
  logic       data_we = 1'b0;
  logic [7:0] data = '0;
  logic       tick = 1'b0;
  logic txd, rdy, empty, rx_en, mr_stb, rx_stb, err_stb, brk_stb;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) tick <= 1'b0;
    else        tick <= ~tick;
  end

  uart_cmd_tx #(.DATA_W(8), .OVS(4)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_i(cmd),
    .data_we_i(data_we), .data_i(data), .tick16_i(tick),
    .txd_o(txd), .tx_rdy_o(rdy), .tx_empty_o(empty), .rx_en_o(rx_en),
    .mr_ptr_rst_o(mr_stb), .rx_rst_o(rx_stb), .err_clr_o(err_stb),
    .brk_int_clr_o(brk_stb)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr_cmd(input logic [7:0] c);
    @(negedge clk); cmd_we = 1'b1; cmd = c;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic wr_data(input logic [7:0] d);
    @(negedge clk); data_we = 1'b1; data = d;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic wait_rdy();
    int n = 0;
    while (!rdy && n < 40 * BIT) begin @(negedge clk); n++; end
  endtask

  task automatic rx_char(input bit already_low, output logic [7:0] d,
                         output bit ok, output int wait_n);
    ok = 1'b1; d = '0; wait_n = 0;
    if (!already_low) begin
      @(negedge clk);
      while (txd && wait_n < 40 * BIT) begin @(negedge clk); wait_n++; end
      if (txd) begin ok = 1'b0; return; end
    end
    repeat (3) @(negedge clk);
    if (txd) ok = 1'b0;
    for (int i = 0; i < 8; i++) begin
      repeat (BIT) @(negedge clk);
      d[i] = txd;
    end
    repeat (BIT) @(negedge clk);
    if (!txd) ok = 1'b0;
  endtask

  task automatic quiet(input int n, output bit stayed_high);
    stayed_high = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!txd) stayed_high = 1'b0;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(txd && !rdy && !empty && !rx_en, "R13", "reset idle flags",
        {txd, rdy, empty, rx_en}, 4'b1000);
    chk({mr_stb, rx_stb, err_stb, brk_stb} == 0, "R3", "reset strobes",
        {mr_stb, rx_stb, err_stb, brk_stb}, 0);
  endtask

  task automatic t_fields();
    wr_cmd(8'h84);
    chk(rdy && empty, "R4", "enable raises rdy/empty", {rdy, empty}, 3);
    wr_cmd(8'h80);
    chk(rdy && !rx_en, "R1", "bit7 alone no effect", {rdy, rx_en}, 2);
    wr_cmd(8'h0C);
    chk(!rdy && !empty, "R1", "tx enable+disable gives disable", {rdy, empty}, 0);
    wr_cmd(8'h01);
    chk(rx_en, "R2", "rx enable", rx_en, 1);
    wr_cmd(8'h03);
    chk(!rx_en, "R2", "rx enable+disable gives disable", rx_en, 0);
    wr_cmd(8'h01);
    wr_cmd(8'h21);
    chk(!rx_en, "R2", "rx reset overrides enable", rx_en, 0);
  endtask

  task automatic t_strobe(input logic [2:0] code, input int idx);
    int cnt[4] = '{0, 0, 0, 0};
    logic [3:0] v;
    @(negedge clk); cmd_we = 1'b1; cmd = {1'b0, code, 4'b0};
    @(negedge clk); cmd_we = 1'b0;
    for (int k = 0; k < 4; k++) begin
      v = {brk_stb, err_stb, rx_stb, mr_stb};
      for (int j = 0; j < 4; j++) if (v[j]) cnt[j]++;
      @(negedge clk);
    end
    for (int j = 0; j < 4; j++)
      chk(cnt[j] == ((j == idx) ? 1 : 0), "R3", $sformatf("strobe %0d for code %0d", j, code),
          cnt[j], (j == idx) ? 1 : 0);
  endtask

  task automatic t_frame();
    logic [7:0] d; bit ok; int n;
    wr_cmd(8'h04);
    fork
      rx_char(1'b0, d, ok, n);
      begin
        wr_data(8'hA5);
        chk(!rdy && !empty, "R6", "rdy low while held", {rdy, empty}, 0);
      end
    join
    chk(ok && d == 8'hA5, "R5", "frame A5", d, 8'hA5);
    repeat (BIT) @(negedge clk);
    chk(empty && rdy && txd, "R13", "empty after frame", {empty, rdy, txd}, 7);
  endtask

  task automatic t_b2b();
    logic [7:0] d1, d2; bit ok1, ok2, hi; int n1, n2;
    fork
      begin
        rx_char(1'b0, d1, ok1, n1);
        rx_char(1'b0, d2, ok2, n2);
      end
      begin
        wr_data(8'h3C);
        wait_rdy();
        wr_data(8'hC3);
        wr_data(8'hFF); // dropped, register full
        chk(!rdy, "R6", "rdy low after second write", rdy, 0);
      end
    join
    chk(ok1 && d1 == 8'h3C, "R5", "first b2b char", d1, 8'h3C);
    chk(ok2 && d2 == 8'hC3, "R7", "second b2b char", d2, 8'hC3);
    chk(n2 <= BIT, "R7", "no gap between frames", n2, BIT);
    quiet(3 * BIT, hi);
    chk(hi && empty, "R6", "write while full dropped", {hi, empty}, 3);
  endtask

  task automatic t_break_idle();
    logic [7:0] d; bit ok; int n = 0, h;
    wr_cmd(8'h60);
    while (txd && n < 3 * BIT) begin @(negedge clk); n++; end
    chk(!txd && n <= 2 * BIT, "R9", "break low from idle", n, 2 * BIT);
    chk(!empty, "R13", "empty low during break", empty, 0);
    wr_data(8'h81);
    chk(!rdy, "R6", "char held during break", rdy, 0);
    repeat (2 * BIT) @(negedge clk);
    chk(!txd, "R10", "break holds while char queued", txd, 0);
    wr_cmd(8'h70);
    n = 0;
    while (!txd && n < 3 * BIT) begin @(negedge clk); n++; end
    chk(txd && n <= 2 * BIT, "R11", "line high after stop", n, 2 * BIT);
    h = 1;
    @(negedge clk);
    while (txd && h < 10 * BIT) begin h++; @(negedge clk); end
    chk(h >= BIT, "R11", "mark time before next start", h, BIT);
    rx_char(1'b1, d, ok, n);
    chk(ok && d == 8'h81, "R11", "char after break", d, 8'h81);
  endtask

  task automatic t_break_deferred();
    logic [7:0] d1, d2; bit ok1, ok2; int n1, n2, m = 0;
    fork
      begin
        rx_char(1'b0, d1, ok1, n1);
        rx_char(1'b0, d2, ok2, n2);
      end
      begin
        wr_data(8'h5A);
        wr_cmd(8'h60);
        wait_rdy();
        wr_data(8'h96);
      end
    join
    chk(ok1 && d1 == 8'h5A, "R10", "queued char before break", d1, 8'h5A);
    chk(ok2 && d2 == 8'h96, "R10", "later char before break", d2, 8'h96);
    while (txd && m < 3 * BIT) begin @(negedge clk); m++; end
    chk(!txd && m <= BIT, "R10", "break follows last char", m, BIT);
    wr_cmd(8'h70);
    repeat (3 * BIT) @(negedge clk);
    chk(txd && empty, "R11", "idle after release", {txd, empty}, 3);
  endtask

  task automatic t_disable_pending();
    logic [7:0] d; bit ok, hi; int n;
    fork
      rx_char(1'b0, d, ok, n);
      begin
        wr_data(8'h69);
        wr_cmd(8'h08);
        chk(!rdy && !empty, "R4", "disable drops flags", {rdy, empty}, 0);
      end
    join
    chk(ok && d == 8'h69, "R8", "pending char sent after disable", d, 8'h69);
    wr_cmd(8'h60);
    quiet(3 * BIT, hi);
    chk(hi, "R9", "break rejected while disabled", hi, 1);
    wr_cmd(8'h04);
    quiet(3 * BIT, hi);
    chk(hi && empty, "R9", "rejected break not latched", {hi, empty}, 3);
  endtask

  task automatic t_tx_reset();
    bit hi; int n = 0;
    wr_data(8'h00);
    wr_cmd(8'h60);
    while (txd && n < 3 * BIT) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
    wr_cmd(8'h34); // reset plus enable: reset wins
    chk(txd && !rdy && !empty, "R12", "reset mid frame", {txd, rdy, empty}, 4);
    quiet(4 * BIT, hi);
    chk(hi, "R12", "nothing sent after reset", hi, 1);
    wr_data(8'hF0);
    wr_cmd(8'h04);
    chk(empty, "R6", "write while disabled dropped", empty, 1);
    quiet(3 * BIT, hi);
    chk(hi, "R6", "no frame from dropped write", hi, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fields();
    t_strobe(3'b001, 0);
    t_strobe(3'b010, 1);
    t_strobe(3'b100, 2);
    t_strobe(3'b101, 3);
    t_frame();
    t_b2b();
    t_break_idle();
    t_break_deferred();
    t_disable_pending();
    t_tx_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule